// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This unit joins two eight-line priority controllers into a single sixteen-line interrupt source. One controller faces the processor; the other is cascaded behind its line 2. Request inputs are edge-sensitive. Each controller keeps a pending register and an in-service register. Each controller picks its winner by fixed priority, where a lower line number is more urgent. A pending line competes only while it is unmasked and while it is more urgent than every line already in service.

When the cascaded controller has a winner, the unit marks the primary controller's line 2 as pending. This is the same effect as a pulse that goes high and then low on that line. The primary winner drives the interrupt output. An acknowledge strobe moves the primary winner into service. If that winner is line 2, the strobe also moves the cascaded winner into service. One clock later the unit presents an 8-bit vector with a single-cycle valid pulse. The vector's upper five bits are the controller's base and its lower three bits are the line. Base values and masks come in as static inputs. An end-of-interrupt strobe with a global line number releases one in-service bit.

Top module: `cascade_ack_unit`

## Requirements
- R1: After reset, int_o and vec_valid_o are low and every pending and in-service bit is clear.
- R2: A request is recorded only on a low-to-high change of irq_i; holding a line high does not request again. irq_i[2] has no effect, because line 2 belongs to the cascade.
- R3: A line whose bit in mask_i is 1 stays pending but does not raise int_o. Clearing the mask bit lets the request compete.
- R4: Within a controller, the lowest line number wins. A pending line raises int_o only if it is more urgent than every in-service line of its controller.
- R5: When the cascaded controller gains a winner, the primary line 2 becomes pending on the same clock edge. This happens whenever the cascaded winner exists and no acknowledge is taking place.
- R6: An acknowledge on cycle n gives vec_valid_o high for exactly cycle n+1. For a primary winner L other than 2, the vector is {mbase_i, L} and line L moves from pending to in service.
- R7: When the primary winner is line 2 and the cascaded controller has a winner S, both controllers put their line in service and the vector is {sbase_i, S}.
- R8: When the primary winner is line 2 and the cascaded controller has no winner, the vector is {sbase_i, 3'd7}. Primary line 2 goes into service and the cascaded state is left as it was.
- R9: An acknowledge while int_o is low returns {mbase_i, 3'd7} and changes no state.
- R10: An end-of-interrupt strobe clears one in-service bit. Global lines 0-7 select the primary controller and lines 8-15 select line (n-8) of the cascaded controller.
- R11: The cycle after an acknowledge, int_o and the cascade are worked out again from the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Request lines; 0-7 primary, 8-15 cascaded |
| mask_i | input | 16 | Per-line mask, 1 = blocked |
| mbase_i | input | 5 | Primary vector base, upper bits |
| sbase_i | input | 5 | Cascaded vector base, upper bits |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_line_i | input | 4 | Global line released by eoi_i |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector valid pulse |
| vec_o | output | 8 | Interrupt vector |

## Verification
The assertions assume that ack_i and eoi_i are never high in the same cycle. They also assume that the base inputs stay constant across each acknowledge. The bench meets both assumptions by driving every strobe through its own task, which holds the strobe for one cycle and then returns it low. It also sets the bases once, before reset is released. Masks change only between strobes, so no acknowledge sees a mask edge within its cycle.

// File: rtl/cascade_ack_unit.sv
module cascade_ack_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_i,
  input  logic [15:0] mask_i,
  input  logic [4:0]  mbase_i,
  input  logic [4:0]  sbase_i,
  input  logic        ack_i,
  input  logic        eoi_i,
  input  logic [3:0]  eoi_line_i,
  output logic        int_o,
  output logic        vec_valid_o,
  output logic [7:0]  vec_o
);

  function automatic logic [3:0] first_set(input logic [7:0] v);
    logic [3:0] r;
    r = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (v[i]) r = 4'(i);
    return r;
  endfunction

  logic [15:0] irq_q;
  logic [7:0]  m_irr, m_isr, s_irr, s_isr;
  logic [15:0] rise;

  assign rise = irq_i & ~irq_q;

  logic [3:0] m_pri, m_cur, s_pri, s_cur;
  logic       m_hit, s_hit;
  logic [2:0] m_line, s_line;

  assign m_pri  = first_set(m_irr & ~mask_i[7:0]);
  assign m_cur  = first_set(m_isr);
  assign m_hit  = m_pri < m_cur;
  assign m_line = m_pri[2:0];
  assign s_pri  = first_set(s_irr & ~mask_i[15:8]);
  assign s_cur  = first_set(s_isr);
  assign s_hit  = s_pri < s_cur;
  assign s_line = s_pri[2:0];

  assign int_o = m_hit;

  logic       m_take, s_take;
  logic [7:0] m_bit, s_bit, m_eoi, s_eoi;

  assign m_take = ack_i & m_hit;
  assign s_take = m_take & (m_line == 3'd2) & s_hit;
  assign m_bit  = m_take ? (8'd1 << m_line) : 8'd0;
  assign s_bit  = s_take ? (8'd1 << s_line) : 8'd0;
  assign m_eoi  = (eoi_i && !eoi_line_i[3]) ? (8'd1 << eoi_line_i[2:0]) : 8'd0;
  assign s_eoi  = (eoi_i &&  eoi_line_i[3]) ? (8'd1 << eoi_line_i[2:0]) : 8'd0;

  logic [7:0] s_irr_n, s_isr_n, m_irr_n, m_isr_n;
  logic       s_hit_n;

  assign s_irr_n = (s_irr & ~s_bit) | rise[15:8];
  assign s_isr_n = (s_isr | s_bit) & ~s_eoi;
  assign s_hit_n = first_set(s_irr_n & ~mask_i[15:8]) < first_set(s_isr_n);
  assign m_irr_n = (m_irr & ~m_bit) | (rise[7:0] & 8'b1111_1011) | {5'd0, s_hit_n, 2'd0};
  assign m_isr_n = (m_isr | m_bit) & ~m_eoi;

  logic [7:0] vec_n;

  always_comb begin
    if (!m_hit)                vec_n = {mbase_i, 3'd7};
    else if (m_line != 3'd2)   vec_n = {mbase_i, m_line};
    else if (s_hit)            vec_n = {sbase_i, s_line};
    else                       vec_n = {sbase_i, 3'd7};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q       <= '0;
      m_irr       <= '0;
      m_isr       <= '0;
      s_irr       <= '0;
      s_isr       <= '0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      irq_q       <= irq_i;
      m_irr       <= m_irr_n;
      m_isr       <= m_isr_n;
      s_irr       <= s_irr_n;
      s_isr       <= s_isr_n;
      vec_valid_o <= ack_i;
      if (ack_i) vec_o <= vec_n;
    end
  end

endmodule

// File: rtl/cascade_ack_unit_chk.sv
module cascade_ack_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack_i,
  input logic       int_o,
  input logic       vec_valid_o,
  input logic [7:0] vec_o,
  input logic [4:0] mbase_i,
  input logic       s_hit,
  input logic [7:0] m_irr,
  input logic [7:0] m_isr
);

  AST_VALID_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_valid_o);                                           // R6

  AST_VALID_ONLY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !vec_valid_o);                                         // R6

  AST_SPURIOUS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !int_o) |=> vec_o == {$past(mbase_i), 3'd7});           // R9

  AST_CASCADE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && !ack_i) |=> m_irr[2]);                                  // R5

  AST_ISR_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> $countones(m_isr) <= $countones($past(m_isr)));        // R10

endmodule

bind cascade_ack_unit cascade_ack_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .int_o(int_o),
  .vec_valid_o(vec_valid_o), .vec_o(vec_o), .mbase_i(mbase_i),
  .s_hit(s_hit), .m_irr(m_irr), .m_isr(m_isr)
);

// File: tb/cascade_ack_unit_test.sv
module cascade_ack_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_i = '0;
  logic [15:0] mask_i = '0;
  logic [4:0]  mbase_i = 5'h04;
  logic [4:0]  sbase_i = 5'h0E;
  logic        ack_i = 1'b0;
  logic        eoi_i = 1'b0;
  logic [3:0]  eoi_line_i = '0;
  logic        int_o, vec_valid_o;
  logic [7:0]  vec_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] expq[$];
  string      tagq[$];

  always #5 clk = ~clk;

  cascade_ack_unit uut (.*);

  always @(negedge clk) begin
    if (rst_n && vec_valid_o) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R6: unexpected vector valid, vec=%h expected none", vec_o);
      end else begin
        automatic logic [7:0] e = expq.pop_front();
        automatic string t = tagq.pop_front();
        if (vec_o !== e) begin
          errors++;
          $display("FAIL %s: vector actual=%h expected=%h", t, vec_o, e);
        end
      end
    end
  end

  task automatic chk_int(input logic e, input string tag);
    checks++;
    if (int_o !== e) begin
      errors++;
      $display("FAIL %s: int_o actual=%b expected=%b", tag, int_o, e);
    end
  endtask

  task automatic set_irq(input int n, input logic v);
    irq_i[n] = v;
    @(negedge clk);
  endtask

  task automatic set_mask(input int n, input logic v);
    mask_i[n] = v;
    @(negedge clk);
  endtask

  task automatic ack(input logic [7:0] e, input string tag);
    expq.push_back(e);
    tagq.push_back(tag);
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic eoi(input int n);
    eoi_i = 1'b1;
    eoi_line_i = 4'(n);
    @(negedge clk);
    eoi_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_int(1'b0, "R1");
    checks++;
    if (vec_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: vec_valid actual=%b expected=0", vec_valid_o);
    end

    ack(8'h27, "R9");
    chk_int(1'b0, "R11");

    set_irq(5, 1); chk_int(1'b1, "R2");
    ack(8'h25, "R6"); chk_int(1'b0, "R11");
    set_irq(3, 1); chk_int(1'b1, "R4");
    ack(8'h23, "R4");
    set_irq(6, 1); chk_int(1'b0, "R4");
    eoi(3); chk_int(1'b0, "R4");
    eoi(5); chk_int(1'b1, "R10");
    ack(8'h26, "R6");
    eoi(6); chk_int(1'b0, "R2");
    set_irq(3, 0); set_irq(5, 0); set_irq(6, 0);

    set_irq(2, 1); chk_int(1'b0, "R2");
    set_irq(2, 0);

    set_mask(1, 1);
    set_irq(1, 1); chk_int(1'b0, "R3");
    set_mask(1, 0); chk_int(1'b1, "R3");
    ack(8'h21, "R3");
    eoi(1); set_irq(1, 0);

    set_irq(12, 1); chk_int(1'b1, "R5");
    ack(8'h74, "R7"); chk_int(1'b0, "R11");
    eoi(12); eoi(2); chk_int(1'b0, "R10");
    set_irq(12, 0);

    irq_i[1] = 1'b1; irq_i[8] = 1'b1;
    @(negedge clk); chk_int(1'b1, "R4");
    ack(8'h21, "R4"); chk_int(1'b0, "R4");
    eoi(1); chk_int(1'b1, "R5");
    ack(8'h70, "R7");
    eoi(8); eoi(2);
    irq_i[1] = 1'b0; irq_i[8] = 1'b0;
    @(negedge clk);

    set_irq(9, 1); chk_int(1'b1, "R5");
    set_mask(9, 1); chk_int(1'b1, "R8");
    ack(8'h77, "R8"); chk_int(1'b0, "R8");
    set_mask(9, 0); chk_int(1'b0, "R4");
    eoi(2); chk_int(1'b1, "R8");
    ack(8'h71, "R8");
    eoi(9); eoi(2); chk_int(1'b0, "R10");
    set_irq(9, 0);

    irq_i[10] = 1'b1; irq_i[11] = 1'b1;
    @(negedge clk);
    ack(8'h72, "R7");
    eoi(2); chk_int(1'b0, "R10");
    eoi(10); chk_int(1'b1, "R10");
    ack(8'h73, "R7");
    eoi(11); eoi(2); chk_int(1'b0, "R10");

    repeat (2) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R6: vectors outstanding actual=%0d expected=0", expq.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule